// File: doc/BRIEF.md
# Dual-Mode Serial Clock Rate Generator

This block derives the serial clock of a SPI master from the module clock. A single 13-bit configuration word selects one of two divide schemes and carries the field for each: a linear scheme that divides by an even ratio 2*(N+1), and a power-of-two scheme that divides by 2^M. The block produces two things: a one-cycle half-period enable for the shift logic, and the serial clock level itself. The level idles at the polarity given by `cpol_i`.

A transfer is framed by the level input `xfer_act_i`. Each time it rises, the phase counter starts again from zero, so the first serial clock edge comes exactly one half period after the start. The configuration word may be written at any time. A write made while a transfer runs is parked and only committed once the line is idle again, so the rate never changes within a transfer. With M equal to zero in the power-of-two scheme, the serial clock is the module clock itself, gated by the transfer.

Top module: `sclk_divgen`

## Requirements
- R1: With bit 12 of the configuration word at 1 (linear scheme), each half period of the serial clock lasts N+1 module cycles, where N is bits 7:0. The full period is 2*(N+1) cycles.
- R2: With bit 12 at 0 and M (bits 11:8) of 1 or more, each half period lasts 2^(M-1) module cycles, so the full period is 2^M cycles.
- R3: With bit 12 at 0 and M at 0, the half-period enable is high on every active cycle. The serial clock equals `cpol_i` while the module clock is low and its inverse while the module clock is high. The reset value of the configuration word is all zeros, which selects this scheme.
- R4: `tick_o` is high for exactly one cycle per half period and only while a transfer is active. The serial clock changes level on the clock edge that ends each tick cycle, and at no other edge during a transfer.
- R5: On every rise of `xfer_act_i`, the count restarts from zero, even if the previous transfer ended mid-period. The first tick falls in the H-th active cycle, where H is the half period, so the first level change is visible H cycles after the start.
- R6: While `xfer_act_i` is low, `sclk_o` equals `cpol_i` and `tick_o` is low, including during reset.
- R7: A write made while no transfer is active takes effect from the next cycle. A write made during a transfer, including in its last active cycle, has no effect until the line is idle. It is then committed on the first idle edge. When several writes are made in one transfer, the last one wins.
- R8: The linear scheme reaches a ratio of 512 with N at 255, giving half periods of 256 cycles.
- R9: The field of the scheme that is not selected has no effect on the rate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we_i | input | 1 | Write strobe for the configuration word |
| cfg_wdata_i | input | 13 | Configuration word: N in 7:0, M in 11:8, scheme select in 12 |
| xfer_act_i | input | 1 | High for the duration of a transfer |
| cpol_i | input | 1 | Idle level of the serial clock |
| tick_o | output | 1 | Half-period enable for the shift logic |
| sclk_o | output | 1 | Serial clock level |

## Verification
Two events can land in the same cycle. The first is a configuration write in the last active cycle of a transfer. The bench provokes it by raising the write strobe while `xfer_act_i` is still high and dropping both together, then expects the old rate to hold to the end and the new rate to apply from the next transfer. The second is a transfer that ends, or restarts, while a half period is partly counted. A short transfer cut off mid-count is followed at once by a new one, and the bench expects the first tick of the new transfer a full half period after its start, not the remainder. A behavioural model with its own counters and parked-write state is compared with both outputs on every cycle. It is also checked in the high phase of the clock for the gated mode.

// File: rtl/spi_clkdiv_pkg.sv
package spi_clkdiv_pkg;

   typedef enum logic {
      DIV_POW2 = 1'b0,
      DIV_LIN  = 1'b1
   } div_mode_e;

   localparam int unsigned DEF_LIN_W = 8;
   localparam int unsigned DEF_EXP_W = 4;

   // width needed to hold (half period - 1) for either scheme
   function automatic int unsigned half_cnt_w(int unsigned lin_w, int unsigned exp_w);
      int unsigned pw;
      pw = (1 << exp_w) - 2;
      if (pw < 1) pw = 1;
      return (lin_w > pw) ? lin_w : pw;
   endfunction

endpackage

// File: rtl/sck_cfg_hold.sv
module sck_cfg_hold #(
   parameter int unsigned CFG_W = 13
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we,
   input  logic [CFG_W-1:0] wdata,
   input  logic             busy,
   output logic [CFG_W-1:0] cfg_q
);

   logic [CFG_W-1:0] park_q;
   logic             park_v;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q  <= '0;
         park_q <= '0;
         park_v <= 1'b0;
      end else if (we && !busy) begin
         cfg_q  <= wdata;
         park_v <= 1'b0;
      end else if (we) begin
         park_q <= wdata;
         park_v <= 1'b1;
      end else if (!busy && park_v) begin
         cfg_q  <= park_q;
         park_v <= 1'b0;
      end
   end

   // R7: rate word frozen while a transfer runs
   assert_cfg_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> $stable(cfg_q));

endmodule

// File: rtl/sck_half_sel.sv
module sck_half_sel
   import spi_clkdiv_pkg::*;
#(
   parameter int unsigned LIN_W = DEF_LIN_W,
   parameter int unsigned EXP_W = DEF_EXP_W,
   parameter int unsigned CNT_W = half_cnt_w(LIN_W, EXP_W)
) (
   input  logic [LIN_W+EXP_W:0] cfg,
   output logic [CNT_W-1:0]     half_m1,
   output logic                 bypass
);

   localparam int unsigned SEL_BIT = LIN_W + EXP_W;

   logic [LIN_W-1:0] lin_f;
   logic [EXP_W-1:0] exp_f;
   div_mode_e        mode;
   logic [CNT_W:0]   pow_one;

   assign lin_f = cfg[LIN_W-1:0];
   assign exp_f = cfg[SEL_BIT-1:LIN_W];
   assign mode  = div_mode_e'(cfg[SEL_BIT]);

   always_comb begin
      pow_one = '0;
      if (exp_f != '0) pow_one = {{CNT_W{1'b0}}, 1'b1} << (exp_f - 1'b1);
   end

   always_comb begin
      bypass = 1'b0;
      if (mode == DIV_LIN) begin
         half_m1 = CNT_W'(lin_f);
      end else if (exp_f == '0) begin
         half_m1 = '0;
         bypass  = 1'b1;
      end else begin
         half_m1 = pow_one[CNT_W-1:0] - 1'b1;
      end
   end

endmodule

// File: rtl/sck_phase_cnt.sv
module sck_phase_cnt #(
   parameter int unsigned CNT_W = 14
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [CNT_W-1:0] half_m1,
   output logic             tick
);

   logic [CNT_W-1:0] cnt_q;

   assign tick = run && (cnt_q == half_m1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          cnt_q <= '0;
      else if (!run || tick) cnt_q <= '0;
      else                 cnt_q <= cnt_q + 1'b1;
   end

   // R5: the count never passes the half period of the current rate
   assert_cnt_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
      run |-> (cnt_q <= half_m1));

   // R4: ticks are isolated unless the half period is one cycle
   assert_tick_gap_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && half_m1 != '0) |=> !tick);

endmodule

// File: rtl/sck_level.sv
module sck_level #(
   parameter bit BYPASS_EN = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   input  logic tick,
   input  logic bypass,
   input  logic cpol,
   output logic sclk
);

   logic sclk_q;
   logic byp_eff;

   assign byp_eff = BYPASS_EN && bypass;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)               sclk_q <= 1'b0;
      else if (!run)            sclk_q <= cpol;
      else if (tick && !byp_eff) sclk_q <= ~sclk_q;
   end

   generate
      if (BYPASS_EN) begin : g_gated
         assign sclk = !run ? cpol : (byp_eff ? (cpol ^ clk) : sclk_q);
      end else begin : g_plain
         assign sclk = run ? sclk_q : cpol;
      end
   endgenerate

   // R4: level holds on every active edge without a tick
   assert_hold_level_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !tick) |=> $stable(sclk_q));

   // R4: level flips on the edge that closes a tick
   assert_toggle_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (run && tick && !byp_eff) |=> (sclk_q != $past(sclk_q)));

endmodule

// File: rtl/sclk_divgen.sv
module sclk_divgen
   import spi_clkdiv_pkg::*;
#(
   parameter int unsigned LIN_W     = DEF_LIN_W,
   parameter int unsigned EXP_W     = DEF_EXP_W,
   parameter bit          BYPASS_EN = 1'b1
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   cfg_we_i,
   input  logic [LIN_W+EXP_W:0]   cfg_wdata_i,
   input  logic                   xfer_act_i,
   input  logic                   cpol_i,
   output logic                   tick_o,
   output logic                   sclk_o
);

   localparam int unsigned CFG_W = LIN_W + EXP_W + 1;
   localparam int unsigned CNT_W = half_cnt_w(LIN_W, EXP_W);

   generate
      if (LIN_W < 1 || EXP_W < 1 || EXP_W > 5) begin : g_bad_cfg
         $error("sclk_divgen: LIN_W must be >= 1 and EXP_W in 1..5");
      end
   endgenerate

   logic [CFG_W-1:0] cfg_q;
   logic [CNT_W-1:0] half_m1;
   logic             bypass;

   sck_cfg_hold #(.CFG_W(CFG_W)) u_cfg (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (cfg_we_i),
      .wdata (cfg_wdata_i),
      .busy  (xfer_act_i),
      .cfg_q (cfg_q)
   );

   sck_half_sel #(.LIN_W(LIN_W), .EXP_W(EXP_W), .CNT_W(CNT_W)) u_sel (
      .cfg     (cfg_q),
      .half_m1 (half_m1),
      .bypass  (bypass)
   );

   sck_phase_cnt #(.CNT_W(CNT_W)) u_cnt (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (xfer_act_i),
      .half_m1 (half_m1),
      .tick    (tick_o)
   );

   sck_level #(.BYPASS_EN(BYPASS_EN)) u_lvl (
      .clk    (clk),
      .rst_n  (rst_n),
      .run    (xfer_act_i),
      .tick   (tick_o),
      .bypass (bypass),
      .cpol   (cpol_i),
      .sclk   (sclk_o)
   );

   // R6: idle line rests at the polarity level with no enables
   assert_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !xfer_act_i |-> (!tick_o && sclk_o == cpol_i));

endmodule

// File: tb/sclk_divgen_test.sv
`timescale 1ns/1ps
module sclk_divgen_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        we = 1'b0;
   logic [12:0] wd = '0;
   logic        act = 1'b0;
   logic        cpol = 1'b0;
   logic        tick;
   logic        sclk;

   int    total = 0;
   int    bad = 0;
   int    cycles = 0;
   string tag = "R6";

   // behavioural reference state
   int mcfg = 0, mpend = 0, mcnt = 0;
   bit mpv = 0, msclk = 0;

   always #4 clk = ~clk;

   sclk_divgen uut (
      .clk (clk), .rst_n (rst_n), .cfg_we_i (we), .cfg_wdata_i (wd),
      .xfer_act_i (act), .cpol_i (cpol), .tick_o (tick), .sclk_o (sclk)
   );

   function automatic int half_of(int c);
      int m, n;
      m = (c >> 8) & 15;
      n = c & 255;
      if (((c >> 12) & 1) == 1) return n + 1;
      if (m == 0) return 1;
      return 1 << (m - 1);
   endfunction

   function automatic bit gated(int c);
      return (((c >> 12) & 1) == 0) && (((c >> 8) & 15) == 0);
   endfunction

   // model update on each clock edge
   always @(posedge clk) begin
      cycles++;
      if (!rst_n) begin
         mcfg = 0; mpv = 0; mcnt = 0; msclk = 0;
      end else begin
         if (act) begin
            if (mcnt == half_of(mcfg) - 1) begin
               mcnt = 0;
               if (!gated(mcfg)) msclk = ~msclk;
            end else begin
               mcnt = mcnt + 1;
            end
         end else begin
            mcnt = 0;
            msclk = cpol;
         end
         if (we && !act) begin
            mcfg = wd; mpv = 0;
         end else if (we) begin
            mpend = wd; mpv = 1;
         end else if (!act && mpv) begin
            mcfg = mpend; mpv = 0;
         end
      end
   end

   task automatic check(string req, string what, logic got, logic exp);
      total++;
      if (got !== exp) begin
         bad++;
         $display("FAIL %s %s: got=%0b expected=%0b at cycle %0d", req, what, got, exp, cycles);
      end
   endtask

   // per-cycle comparison in the low phase
   always @(negedge clk) begin
      logic et, es;
      et = act && rst_n && (mcnt == half_of(mcfg) - 1);
      if (!rst_n) et = 1'b0;
      es = (!act || gated(mcfg)) ? cpol : msclk;
      check(tag, "tick", tick, et);
      check(tag, "sclk", sclk, es);
   end

   // gated mode seen in the high phase (R3)
   always @(posedge clk) begin
      #2;
      if (rst_n && act && gated(mcfg)) check("R3", "sclk high phase", sclk, ~cpol);
   end

   task automatic cyc(input logic a, input logic w, input logic [12:0] d, input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk); #1;
         act = a; we = w; wd = d;
      end
   endtask

   function automatic logic [12:0] lin(int n, int m);
      return {1'b1, 4'(m), 8'(n)};
   endfunction

   function automatic logic [12:0] pw(int m, int n);
      return {1'b0, 4'(m), 8'(n)};
   endfunction

   initial begin
      // R6: reset and idle
      cyc(0, 0, '0, 3);
      rst_n = 1'b1;
      cyc(0, 0, '0, 2);
      // R1: linear scheme
      tag = "R1";
      cyc(0, 1, lin(2, 0), 1);
      cyc(0, 0, '0, 2);
      cyc(1, 0, '0, 20);
      cyc(0, 0, '0, 3);
      cpol = 1'b1;
      cyc(0, 1, lin(0, 0), 1);
      cyc(1, 0, '0, 10);
      cyc(0, 0, '0, 2);
      // R2: power-of-two scheme
      tag = "R2";
      cyc(0, 1, pw(3, 0), 1);
      cyc(1, 0, '0, 24);
      cyc(0, 1, pw(1, 0), 1);
      cyc(1, 0, '0, 8);
      cyc(0, 0, '0, 2);
      // R3: gated module clock
      tag = "R3";
      cyc(0, 1, pw(0, 0), 1);
      cyc(1, 0, '0, 6);
      cyc(0, 0, '0, 2);
      cpol = 1'b0;
      // R4: enable pulse spacing, polarity low
      tag = "R4";
      cyc(0, 1, lin(2, 9), 1);
      cyc(1, 0, '0, 30);
      cyc(0, 0, '0, 2);
      // R9: unselected field ignored
      tag = "R9";
      cyc(0, 1, lin(1, 7), 1);
      cyc(1, 0, '0, 12);
      cyc(0, 1, pw(2, 200), 1);
      cyc(1, 0, '0, 12);
      // R5: restart mid-count, then back to back
      tag = "R5";
      cyc(0, 1, pw(3, 0), 1);
      cyc(1, 0, '0, 5);
      cyc(0, 0, '0, 1);
      cyc(1, 0, '0, 12);
      cyc(0, 0, '0, 2);
      // R7: parked writes, last in final active cycle
      tag = "R7";
      cyc(0, 1, lin(1, 0), 1);
      cyc(1, 0, '0, 3);
      cyc(1, 1, lin(5, 0), 1);
      cyc(1, 0, '0, 6);
      cyc(1, 1, lin(3, 0), 1);
      cyc(0, 0, '0, 2);
      cyc(1, 0, '0, 20);
      cyc(0, 0, '0, 2);
      // R8: largest linear ratio
      tag = "R8";
      cyc(0, 1, lin(255, 0), 1);
      cyc(1, 0, '0, 1100);
      cyc(0, 0, '0, 3);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #200000;
      bad++;
      total++;
      $display("FAIL watchdog: got=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule